// File: doc/BRIEF.md
# Latency-Balancing Inverting Route Chain

This block models routing paths built from inverting pipeline elements that converge on one destination logic block. Two alternating evaluation strobes drive the elements. The horizontal strobe `h_eva` moves the elements at even positions, and the vertical strobe `v_eva` moves those at odd positions. One evaluation period is one `h_eva` pulse followed by one `v_eva` pulse.

Every element stores the complement of its predecessor. Each route therefore always crosses an even number of elements, and the bit reaches the destination with its original polarity. Each path has a fixed base latency in periods. A run-time pad value per path inserts extra element pairs, so paths of different lengths can be brought to a common latency.

Every word carries a data bit, a wave tag and an occupancy flag. The destination is a three-state machine that evaluates on each `h_eva` pulse:

- **FILL**: at least one path tap holds no valid word.
- **ALIGNED**: every tap is valid and all the tags are equal.
- **SKEWED**: every tap is valid but the tags disagree.

The machine can move from any state to any other, and the move depends only on what the taps hold at that pulse:

- **to_fill**: some occupancy flag at the taps is clear.
- **to_aligned**: all flags are set and all tags match.
- **to_skewed**: all flags are set and the tags differ.

In ALIGNED the machine issues one result per period: all the data bits and the common tag. In SKEWED it flags a wave error.

Top module: `rt_balance_route`

## Requirements
- R1: After reset, `res_valid` and `wave_err` are 0 and the destination is in FILL.
- R2: Each routed data bit reaches the destination with its injected polarity, because the number of inverting elements on every route is even.
- R3: A word injected on path i at an `h_eva` pulse is seen by the destination exactly BASE_i + pad_i pulses of `h_eva` later.
- R4: A pad request above MAX_PAD (16) acts as MAX_PAD.
- R5: While any tap holds no valid word, the destination stays in FILL with `res_valid`=0 and `wave_err`=0.
- R6: When all taps are valid with equal tags at an `h_eva` pulse, the destination enters ALIGNED. In ALIGNED, `res_valid`=1, `res_tag` is the common tag, and bit i of `res_data` is path i's data bit.
- R7: When all taps are valid but the tags differ, the destination enters SKEWED with `wave_err`=1 and `res_valid`=0.
- R8: A word injected with `in_valid`=0 on one path makes the destination fall to FILL for exactly the period in which that word arrives. It recovers on the next period.
- R9: The destination outputs change only on a clock edge where `h_eva` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_eva | input | 1 | Horizontal evaluation strobe (even elements, destination) |
| v_eva | input | 1 | Vertical evaluation strobe (odd elements) |
| in_data | input | N_PATH | Data bit per path |
| in_tag | input | N_PATH*TAG_W | Wave tag per path, path i at bits [i*TAG_W +: TAG_W] |
| in_valid | input | N_PATH | Occupancy flag per path |
| pad_sel | input | N_PATH*PAD_W | Extra periods per path, path i at [i*PAD_W +: PAD_W] |
| res_valid | output | 1 | Destination result valid (ALIGNED) |
| res_data | output | N_PATH | Destination data bits, bit i from path i |
| res_tag | output | TAG_W | Tag of the issued wave |
| wave_err | output | 1 | Converging inputs belong to different waves (SKEWED) |

## Verification
The bench uses the default build: three paths with base latencies of 2, 3 and 5 periods, 4-bit tags, and pads up to 16. These settings reproduce the case where the 2- and 3-period paths are padded up to the 5-period one. They also allow runs long enough for the tags to wrap, and a pad request of 31 that exercises the clamp at a common latency of 18. Deliberately unequal pads expose SKEWED, and a single invalid injection exposes the one-period bubble.

// File: rtl/rt_balance_pkg.sv
package rt_balance_pkg;

    typedef enum logic [1:0] {
        ST_FILL    = 2'd0,
        ST_ALIGNED = 2'd1,
        ST_SKEWED  = 2'd2
    } merge_state_t;

    // Limit a requested pad count to the depth that was built.
    function automatic int unsigned eff_pad(input int unsigned req, input int unsigned lim);
        return (req > lim) ? lim : req;
    endfunction

endpackage

// File: rtl/rt_route_chain.sv
module rt_route_chain
    import rt_balance_pkg::*;
#(
    parameter int W       = 6,
    parameter int BASE    = 2,
    parameter int MAX_PAD = 16,
    parameter int PAD_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_eva,
    input  logic             v_eva,
    input  logic [W-1:0]     in_word,
    input  logic [PAD_W-1:0] pad,
    output logic [W-1:0]     tap_word
);
    localparam int NSTG  = 2 * (BASE + MAX_PAD);
    localparam int IDX_W = $clog2(NSTG);

    logic [W-1:0] stg [NSTG];

    for (genvar k = 0; k < NSTG; k++) begin : g_elem
        // Even elements hold complemented values, so an empty word is all ones.
        localparam logic [W-1:0] RST_V = ((k % 2) == 0) ? {W{1'b1}} : {W{1'b0}};
        logic [W-1:0] q;
        logic         upd;
        logic [W-1:0] src;

        assign upd = ((k % 2) == 0) ? h_eva : v_eva;
        if (k == 0) begin : g_head
            assign src = in_word;
        end else begin : g_body
            assign src = stg[k-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RST_V;
            else if (upd) q <= ~src;
        end
        assign stg[k] = q;
    end

    // The tap sits after an even count of elements: true polarity.
    logic [IDX_W-1:0] idx;
    always_comb begin
        idx      = IDX_W'(2 * (BASE + int'(eff_pad(int'(pad), MAX_PAD))) - 1);
        tap_word = stg[idx];
    end

endmodule

// File: rtl/rt_wave_merge.sv
module rt_wave_merge
    import rt_balance_pkg::*;
#(
    parameter int N_PATH = 3,
    parameter int TAG_W  = 4,
    parameter int W      = TAG_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                h_eva,
    input  logic [N_PATH*W-1:0] tap_flat,
    output logic                res_valid,
    output logic [N_PATH-1:0]   res_data,
    output logic [TAG_W-1:0]    res_tag,
    output logic                wave_err
);
    merge_state_t state, nxt;
    logic         all_v;
    logic         same;
    logic [N_PATH-1:0] cur_data;
    logic [TAG_W-1:0]  tag0;

    always_comb begin
        all_v = 1'b1;
        same  = 1'b1;
        tag0  = tap_flat[1 +: TAG_W];
        for (int i = 0; i < N_PATH; i++) begin
            cur_data[i] = tap_flat[i*W];
            if (!tap_flat[i*W + W - 1]) all_v = 1'b0;
            if (tap_flat[i*W + 1 +: TAG_W] != tag0) same = 1'b0;
        end
        if (!all_v)    nxt = ST_FILL;
        else if (same) nxt = ST_ALIGNED;
        else           nxt = ST_SKEWED;
    end

    // State register: moves only on the destination strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_FILL;
        else if (h_eva) state <= nxt;
    end

    // Output process: result word captured when a matched wave is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
            res_tag  <= '0;
        end else if (h_eva) begin
            unique case (nxt)
                ST_ALIGNED: begin
                    res_data <= cur_data;
                    res_tag  <= tag0;
                end
                ST_FILL, ST_SKEWED: begin
                    res_data <= res_data;
                    res_tag  <= res_tag;
                end
                default: begin
                    res_data <= res_data;
                    res_tag  <= res_tag;
                end
            endcase
        end
    end

    assign res_valid = (state == ST_ALIGNED);
    assign wave_err  = (state == ST_SKEWED);

endmodule

// File: rtl/rt_balance_route.sv
module rt_balance_route
    import rt_balance_pkg::*;
#(
    parameter int N_PATH                 = 3,
    parameter int TAG_W                  = 4,
    parameter int MAX_PAD                = 16,
    parameter logic [N_PATH*8-1:0] BASE_LAT = {8'd5, 8'd3, 8'd2},
    localparam int PAD_W                 = $clog2(MAX_PAD + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    h_eva,
    input  logic                    v_eva,
    input  logic [N_PATH-1:0]       in_data,
    input  logic [N_PATH*TAG_W-1:0] in_tag,
    input  logic [N_PATH-1:0]       in_valid,
    input  logic [N_PATH*PAD_W-1:0] pad_sel,
    output logic                    res_valid,
    output logic [N_PATH-1:0]       res_data,
    output logic [TAG_W-1:0]        res_tag,
    output logic                    wave_err
);
    localparam int W = TAG_W + 2;

    logic [N_PATH*W-1:0] tap_flat;

    for (genvar i = 0; i < N_PATH; i++) begin : g_path
        logic [W-1:0] word_in;
        logic [W-1:0] word_tap;
        assign word_in = {in_valid[i], in_tag[i*TAG_W +: TAG_W], in_data[i]};

        rt_route_chain #(
            .W       (W),
            .BASE    (int'(BASE_LAT[i*8 +: 8])),
            .MAX_PAD (MAX_PAD),
            .PAD_W   (PAD_W)
        ) chain_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .h_eva    (h_eva),
            .v_eva    (v_eva),
            .in_word  (word_in),
            .pad      (pad_sel[i*PAD_W +: PAD_W]),
            .tap_word (word_tap)
        );
        assign tap_flat[i*W +: W] = word_tap;
    end

    rt_wave_merge #(
        .N_PATH (N_PATH),
        .TAG_W  (TAG_W),
        .W      (W)
    ) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_eva     (h_eva),
        .tap_flat  (tap_flat),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_tag   (res_tag),
        .wave_err  (wave_err)
    );

endmodule

// File: rtl/rt_balance_route_chk.sv
module rt_balance_route_chk #(
    parameter int N_PATH = 3,
    parameter int TAG_W  = 4,
    parameter int W      = TAG_W + 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                h_eva,
    input logic [N_PATH*W-1:0] tap_flat,
    input logic                res_valid,
    input logic [N_PATH-1:0]   res_data,
    input logic [TAG_W-1:0]    res_tag,
    input logic                wave_err
);
    logic             c_all_v;
    logic             c_same;
    logic [TAG_W-1:0] c_tag0;

    always_comb begin
        c_all_v = 1'b1;
        c_same  = 1'b1;
        c_tag0  = tap_flat[1 +: TAG_W];
        for (int i = 0; i < N_PATH; i++) begin
            c_all_v = c_all_v & tap_flat[i*W + W - 1];
            c_same  = c_same & (tap_flat[i*W + 1 +: TAG_W] == c_tag0);
        end
    end

    // R9
    stable_off_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !h_eva |=> $stable({res_valid, res_data, res_tag, wave_err}));

    // R7
    excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && wave_err));

    // R5
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_eva && !c_all_v) |=> (!res_valid && !wave_err));

    // R6
    aligned_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_eva && c_all_v && c_same) |=> (res_valid && res_tag == $past(c_tag0)));

    // R7
    skew_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_eva && c_all_v && !c_same) |=> wave_err);

endmodule

bind rt_balance_route rt_balance_route_chk #(
    .N_PATH (N_PATH),
    .TAG_W  (TAG_W),
    .W      (TAG_W + 2)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_eva     (h_eva),
    .tap_flat  (tap_flat),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_tag   (res_tag),
    .wave_err  (wave_err)
);

// File: tb/rt_balance_route_tb_top.sv
`timescale 1ns/1ps
module rt_balance_route_tb_top;
    localparam int N     = 3;
    localparam int TW    = 4;
    localparam int PW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_eva = 1'b0;
    logic          v_eva = 1'b0;
    logic [N-1:0]  in_data = '0;
    logic [N*TW-1:0] in_tag = '0;
    logic [N-1:0]  in_valid = '0;
    logic [N*PW-1:0] pad_sel = '0;
    logic          res_valid;
    logic [N-1:0]  res_data;
    logic [TW-1:0] res_tag;
    logic          wave_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    rt_balance_route dut_i (
        .clk(clk), .rst_n(rst_n), .h_eva(h_eva), .v_eva(v_eva),
        .in_data(in_data), .in_tag(in_tag), .in_valid(in_valid), .pad_sel(pad_sel),
        .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag), .wave_err(wave_err)
    );

    function automatic logic fbit(input int w, input int i);
        int x;
        x = w * 7 + i * 3 + 1;
        return ^x[3:0];
    endfunction

    function automatic logic [N-1:0] fword(input int w);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = fbit(w, i);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int p0, input int p1, input int p2);
        @(negedge clk);
        rst_n = 1'b0;
        h_eva = 1'b0;
        v_eva = 1'b0;
        pad_sel = {PW'(p2), PW'(p1), PW'(p0)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One period: inject at h_eva, sample right after, then v_eva.
    task automatic period(input int p, input logic [N-1:0] vmask);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            in_tag[i*TW +: TW] = TW'(p % 16);
            in_data[i] = fbit(p % 16, i);
        end
        in_valid = vmask;
        h_eva = 1'b1;
        @(negedge clk);
        h_eva = 1'b0;
        @(negedge clk);
        v_eva = 1'b1;
        @(negedge clk);
        v_eva = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(3, 2, 0);
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 wave_err", int'(wave_err), 0);
    endtask

    task automatic expect_run(input string tag, input int p, input int lat);
        if (p < lat) begin
            check({"R5 ", tag, " fill valid"}, int'(res_valid), 0);
            check({"R5 ", tag, " fill err"}, int'(wave_err), 0);
        end else begin
            check({"R6 ", tag, " valid"}, int'(res_valid), 1);
            check({"R3 ", tag, " tag latency"}, int'(res_tag), (p - lat) % 16);
            check({"R2 ", tag, " data polarity"}, int'(res_data), int'(fword((p - lat) % 16)));
        end
    endtask

    task automatic t_aligned();
        do_reset(3, 2, 0);
        for (int p = 0; p < 22; p++) begin
            period(p, '1);
            expect_run("pad5", p, 5);
        end
    endtask

    task automatic t_clamp();
        do_reset(31, 15, 13);
        for (int p = 0; p < 24; p++) begin
            period(p, '1);
            expect_run("R4 clamp18", p, 18);
        end
    endtask

    task automatic t_skew();
        do_reset(0, 2, 0);
        for (int p = 0; p < 10; p++) begin
            period(p, '1);
            if (p < 5) begin
                check("R5 skew fill valid", int'(res_valid), 0);
                check("R5 skew fill err", int'(wave_err), 0);
            end else begin
                check("R7 skew err", int'(wave_err), 1);
                check("R7 skew valid", int'(res_valid), 0);
            end
        end
    endtask

    task automatic t_bubble();
        do_reset(3, 2, 0);
        for (int p = 0; p < 16; p++) begin
            period(p, (p == 7) ? 3'b101 : 3'b111);
            if (p == 12) begin
                check("R8 bubble valid", int'(res_valid), 0);
                check("R8 bubble err", int'(wave_err), 0);
            end else begin
                expect_run("R8 bubble", p, 5);
            end
        end
    endtask

    initial begin
        t_reset();
        t_aligned();
        t_clamp();
        t_skew();
        t_bubble();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule